// File: doc/BRIEF.md
# Execute Region and Entry Guard

This block sits between a security processor's instruction-fetch and load ports and the memory map behind them. Every fetch is checked against three executable windows: a general code ROM, a boot ROM and a system ROM. Two of these windows, the boot ROM and the system ROM, are execute-only. Loads that target them are refused and return zero. Control may enter either of these two ROMs only at a fixed list of entry addresses. Sequential execution inside a ROM, once entered, is unrestricted.

The guard also checks requests to privileged secure services such as the random source, the key store, the unclonable function and the encrypted non-volatile store. Such a request is honoured only while the processor is executing from the system ROM. This is decided from the region of the most recent granted fetch.

All allow/deny decisions are combinational in the cycle of the request, so a refused access never reaches memory. The first violation is latched as a sticky fault with a cause code and an address. Only reset clears it. All region bounds and entry tables are parameters.

Top module: `exec_entry_guard`

## Requirements
- R1: A fetch whose address lies outside all three ROM windows is refused (`if_grant`=0) and, if no fault is latched yet, latches cause code 1 with the fetch address.
- R2: A fetch anywhere inside the code ROM window is granted, whatever region was executing before.
- R3: A load into the boot or system ROM window is refused, returns zero on `ld_rdata` and latches cause code 2 with the load address. Any other load is granted and passes `mem_rdata` through unchanged.
- R4: A fetch into the boot or system ROM, when the last granted fetch was not in that same ROM, is granted only if its address equals one of that ROM's entry addresses. Otherwise it is refused and latches cause code 3 with the fetch address.
- R5: Once a ROM has been entered legally, further fetches at any address inside that same ROM are granted.
- R6: A service request is granted only while the last granted fetch lay in the system ROM. Otherwise it is refused and latches cause code 4 with address 0.
- R7: The fault flag is sticky. Once set, its cause and address hold the first violation's values until reset, and only reset clears them.
- R8: Grant outputs and `ld_rdata` respond in the same cycle as the request, with no register between request and decision.
- R9: A refused fetch does not change the tracked region, so a repeated bad entry attempt is still refused.
- R10: When several violations occur in the same cycle, the latched cause follows the priority fetch (1 or 3) over load (2) over service (4).
- R11: After reset the fault flag, cause and address are all zero. No region is tracked, so a service request is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously upstream |
| if_req | input | 1 | Instruction fetch request |
| if_addr | input | AW | Fetch address |
| if_grant | output | 1 | Fetch allowed to proceed to memory |
| ld_req | input | 1 | Data load request |
| ld_addr | input | AW | Load address |
| mem_rdata | input | DW | Read data returned by memory |
| ld_grant | output | 1 | Load allowed to proceed to memory |
| ld_rdata | output | DW | Load data to the processor, zero when refused |
| svc_req | input | 1 | Privileged secure-service request |
| svc_grant | output | 1 | Service request allowed |
| fault | output | 1 | Sticky violation flag |
| fault_cause | output | 3 | Cause of the first violation (0 none, 1 range, 2 execute-only read, 3 bad entry, 4 service) |
| fault_addr | output | AW | Address of the first violation |

## Verification
Some properties are checked by the assertions on every cycle:
- a granted fetch always falls inside a ROM window;
- a load into an execute-only ROM never gets a grant or non-zero data;
- a service grant implies the tracked region is the system ROM;
- a granted ROM entry from outside matches the entry table;
- the tracked region does not move on refused fetches;
- the latched fault, cause and address never change until reset.

Other behaviours can only be shown by the bench's scenarios:
- the exact cause codes and addresses recorded;
- the priority when several violations coincide;
- legal entry followed by free sequential execution;
- window edges;
- that reset clears the fault.

// File: rtl/xg_pkg.sv
package xg_pkg;

  localparam int MAX_ENTRY = 8;

  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_CODE = 2'd1,
    RG_BOOT = 2'd2,
    RG_SYS  = 2'd3
  } region_e;

  typedef enum logic [2:0] {
    FC_NONE        = 3'd0,
    FC_FETCH_RANGE = 3'd1,
    FC_XO_READ     = 3'd2,
    FC_BAD_ENTRY   = 3'd3,
    FC_SVC         = 3'd4
  } cause_e;

endpackage

// File: rtl/xg_region_decode.sv
module xg_region_decode #(
  parameter int            AW        = 32,
  parameter logic [AW-1:0] CODE_BASE = '0,
  parameter logic [AW-1:0] CODE_SIZE = '0,
  parameter logic [AW-1:0] BOOT_BASE = '0,
  parameter logic [AW-1:0] BOOT_SIZE = '0,
  parameter logic [AW-1:0] SYS_BASE  = '0,
  parameter logic [AW-1:0] SYS_SIZE  = '0
) (
  input  logic [AW-1:0]    addr,
  output xg_pkg::region_e  region
);
  import xg_pkg::*;

  // Widened by one bit so base+size never wraps.
  localparam int WW = AW + 1;

  function automatic logic in_window(input logic [AW-1:0] a,
                                     input logic [AW-1:0] base,
                                     input logic [AW-1:0] size);
    logic [WW-1:0] lo;
    logic [WW-1:0] hi;
    logic [WW-1:0] aw;
    lo = {1'b0, base};
    hi = {1'b0, base} + {1'b0, size};
    aw = {1'b0, a};
    return (aw >= lo) && (aw < hi);
  endfunction

  logic hit_code;
  logic hit_boot;
  logic hit_sys;

  always_comb begin
    hit_code = in_window(addr, CODE_BASE, CODE_SIZE);
    hit_boot = in_window(addr, BOOT_BASE, BOOT_SIZE);
    hit_sys  = in_window(addr, SYS_BASE,  SYS_SIZE);
  end

  // Fixed precedence if windows were ever configured to overlap.
  always_comb begin
    if (hit_code)      region = RG_CODE;
    else if (hit_boot) region = RG_BOOT;
    else if (hit_sys)  region = RG_SYS;
    else               region = RG_NONE;
  end

endmodule

// File: rtl/xg_entry_match.sv
module xg_entry_match #(
  parameter int AW   = 32,
  parameter int NENT = 1,
  parameter logic [xg_pkg::MAX_ENTRY-1:0][AW-1:0] TABLE = '0
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  import xg_pkg::*;

  logic [MAX_ENTRY-1:0] slot_hit;

  // One comparator per populated slot; unused slots never match.
  for (genvar i = 0; i < MAX_ENTRY; i++) begin : g_slot
    if (i < NENT) begin : g_live
      assign slot_hit[i] = (addr == TABLE[i]);
    end else begin : g_dead
      assign slot_hit[i] = 1'b0;
    end
  end

  assign hit = |slot_hit;

endmodule

// File: rtl/xg_fault_latch.sv
module xg_fault_latch #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          viol,
  input  logic [2:0]    viol_cause,
  input  logic [AW-1:0] viol_addr,
  output logic          fault,
  output logic [2:0]    fault_cause,
  output logic [AW-1:0] fault_addr
);

  logic          fault_q;
  logic [2:0]    cause_q;
  logic [AW-1:0] addr_q;
  logic          capture_en;

  // Only the first violation is recorded.
  always_comb begin
    capture_en = viol && !fault_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      cause_q <= '0;
      addr_q  <= '0;
    end else if (capture_en) begin
      fault_q <= 1'b1;
      cause_q <= viol_cause;
      addr_q  <= viol_addr;
    end
  end

  assign fault       = fault_q;
  assign fault_cause = cause_q;
  assign fault_addr  = addr_q;

  a_r7_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |=> fault_q);
  a_r7_cause_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |=> $stable(cause_q));
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |=> $stable(addr_q));
  a_r7_cause_valid: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |-> (cause_q != 3'd0));

endmodule

// File: rtl/exec_entry_guard.sv
module exec_entry_guard #(
  parameter int            AW        = 32,
  parameter int            DW        = 32,
  parameter logic [AW-1:0] CODE_BASE = 32'h0000_0000,
  parameter logic [AW-1:0] CODE_SIZE = 32'h0001_0000,
  parameter logic [AW-1:0] BOOT_BASE = 32'h0002_0000,
  parameter logic [AW-1:0] BOOT_SIZE = 32'h0000_1000,
  parameter logic [AW-1:0] SYS_BASE  = 32'h0003_0000,
  parameter logic [AW-1:0] SYS_SIZE  = 32'h0000_4000,
  parameter int            BOOT_NENT = 2,
  parameter logic [xg_pkg::MAX_ENTRY-1:0][AW-1:0] BOOT_ENTRIES =
    {{6{32'h0}}, 32'h0002_0100, 32'h0002_0000},
  parameter int            SYS_NENT  = 3,
  parameter logic [xg_pkg::MAX_ENTRY-1:0][AW-1:0] SYS_ENTRIES =
    {{5{32'h0}}, 32'h0003_0080, 32'h0003_0040, 32'h0003_0000}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          if_req,
  input  logic [AW-1:0] if_addr,
  output logic          if_grant,
  input  logic          ld_req,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          ld_grant,
  output logic [DW-1:0] ld_rdata,
  input  logic          svc_req,
  output logic          svc_grant,
  output logic          fault,
  output logic [2:0]    fault_cause,
  output logic [AW-1:0] fault_addr
);
  import xg_pkg::*;

  region_e f_reg;
  region_e l_reg;
  region_e region_q;
  region_e region_d;
  logic    boot_hit;
  logic    sys_hit;

  xg_region_decode #(
    .AW(AW), .CODE_BASE(CODE_BASE), .CODE_SIZE(CODE_SIZE),
    .BOOT_BASE(BOOT_BASE), .BOOT_SIZE(BOOT_SIZE),
    .SYS_BASE(SYS_BASE), .SYS_SIZE(SYS_SIZE)
  ) u_fetch_dec (
    .addr   (if_addr),
    .region (f_reg)
  );

  xg_region_decode #(
    .AW(AW), .CODE_BASE(CODE_BASE), .CODE_SIZE(CODE_SIZE),
    .BOOT_BASE(BOOT_BASE), .BOOT_SIZE(BOOT_SIZE),
    .SYS_BASE(SYS_BASE), .SYS_SIZE(SYS_SIZE)
  ) u_load_dec (
    .addr   (ld_addr),
    .region (l_reg)
  );

  xg_entry_match #(.AW(AW), .NENT(BOOT_NENT), .TABLE(BOOT_ENTRIES)) u_boot_ent (
    .addr (if_addr),
    .hit  (boot_hit)
  );

  xg_entry_match #(.AW(AW), .NENT(SYS_NENT), .TABLE(SYS_ENTRIES)) u_sys_ent (
    .addr (if_addr),
    .hit  (sys_hit)
  );

  // Fetch decision
  logic entering_boot;
  logic entering_sys;
  logic f_range_bad;
  logic f_entry_bad;

  always_comb begin
    entering_boot = (f_reg == RG_BOOT) && (region_q != RG_BOOT);
    entering_sys  = (f_reg == RG_SYS)  && (region_q != RG_SYS);
    f_range_bad   = if_req && (f_reg == RG_NONE);
    f_entry_bad   = if_req && ((entering_boot && !boot_hit) ||
                               (entering_sys  && !sys_hit));
    if_grant      = if_req && !f_range_bad && !f_entry_bad;
  end

  // Load decision: execute-only windows read as zero and are blocked
  logic ld_xo;

  always_comb begin
    ld_xo    = ld_req && ((l_reg == RG_BOOT) || (l_reg == RG_SYS));
    ld_grant = ld_req && !ld_xo;
    ld_rdata = ld_grant ? mem_rdata : '0;
  end

  // Service decision
  logic svc_bad;

  always_comb begin
    svc_grant = svc_req && (region_q == RG_SYS);
    svc_bad   = svc_req && !svc_grant;
  end

  // Violation priority: fetch, then load, then service
  logic          viol;
  logic [2:0]    viol_cause;
  logic [AW-1:0] viol_addr;

  always_comb begin
    viol       = f_range_bad || f_entry_bad || ld_xo || svc_bad;
    viol_cause = FC_NONE;
    viol_addr  = '0;
    if (f_range_bad) begin
      viol_cause = FC_FETCH_RANGE;
      viol_addr  = if_addr;
    end else if (f_entry_bad) begin
      viol_cause = FC_BAD_ENTRY;
      viol_addr  = if_addr;
    end else if (ld_xo) begin
      viol_cause = FC_XO_READ;
      viol_addr  = ld_addr;
    end else if (svc_bad) begin
      viol_cause = FC_SVC;
      viol_addr  = '0;
    end
  end

  // Region tracker: follows granted fetches only
  always_comb begin
    region_d = if_grant ? f_reg : region_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) region_q <= RG_NONE;
    else        region_q <= region_d;
  end

  xg_fault_latch #(.AW(AW)) u_fault (
    .clk         (clk),
    .rst_n       (rst_n),
    .viol        (viol),
    .viol_cause  (viol_cause),
    .viol_addr   (viol_addr),
    .fault       (fault),
    .fault_cause (fault_cause),
    .fault_addr  (fault_addr)
  );

  a_r1_fetch_in_rom: assert property (@(posedge clk) disable iff (!rst_n)
    if_grant |-> (f_reg != RG_NONE));
  a_r3_xo_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && ((l_reg == RG_BOOT) || (l_reg == RG_SYS))) |-> (!ld_grant && (ld_rdata == '0)));
  a_r4_boot_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (if_grant && (f_reg == RG_BOOT) && (region_q != RG_BOOT)) |-> boot_hit);
  a_r4_sys_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (if_grant && (f_reg == RG_SYS) && (region_q != RG_SYS)) |-> sys_hit);
  a_r6_svc_from_sys: assert property (@(posedge clk) disable iff (!rst_n)
    svc_grant |-> (region_q == RG_SYS));
  a_r9_region_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !if_grant |=> $stable(region_q));
  a_r10_fetch_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault && if_req && !if_grant) |=> (fault && ((fault_cause == 3'd1) || (fault_cause == 3'd3))));

endmodule

// File: tb/exec_entry_guard_bench.sv
`timescale 1ns/1ps
module exec_entry_guard_bench;

  localparam logic [31:0] MEMD = 32'hA5A5_5A5A;

  logic        clk;
  logic        rst_n;
  logic        if_req;
  logic [31:0] if_addr;
  logic        if_grant;
  logic        ld_req;
  logic [31:0] ld_addr;
  logic [31:0] mem_rdata;
  logic        ld_grant;
  logic [31:0] ld_rdata;
  logic        svc_req;
  logic        svc_grant;
  logic        fault;
  logic [2:0]  fault_cause;
  logic [31:0] fault_addr;

  int total = 0;
  int bad   = 0;
  logic s_if, s_ld, s_svc;
  logic [31:0] s_rd;

  exec_entry_guard u_exec_entry_guard (
    .clk(clk), .rst_n(rst_n),
    .if_req(if_req), .if_addr(if_addr), .if_grant(if_grant),
    .ld_req(ld_req), .ld_addr(ld_addr), .mem_rdata(mem_rdata),
    .ld_grant(ld_grant), .ld_rdata(ld_rdata),
    .svc_req(svc_req), .svc_grant(svc_grant),
    .fault(fault), .fault_cause(fault_cause), .fault_addr(fault_addr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive just after a falling edge, sample combinational grants 1 ns
  // later, then move to the next falling edge so latched state is visible.
  task automatic cyc(input logic fe, input logic [31:0] fa,
                     input logic le, input logic [31:0] la, input logic se);
    if_req = fe; if_addr = fa; ld_req = le; ld_addr = la; svc_req = se;
    #1;
    s_if = if_grant; s_ld = ld_grant; s_rd = ld_rdata; s_svc = svc_grant;
    @(negedge clk);
    if_req = 1'b0; ld_req = 1'b0; svc_req = 1'b0;
  endtask

  task automatic fetch(input logic [31:0] a); cyc(1'b1, a, 1'b0, '0, 1'b0); endtask
  task automatic load(input logic [31:0] a);  cyc(1'b0, '0, 1'b1, a, 1'b0); endtask
  task automatic svc();                        cyc(1'b0, '0, 1'b0, '0, 1'b1); endtask

  task automatic do_reset();
    rst_n = 1'b0;
    if_req = 1'b0; ld_req = 1'b0; svc_req = 1'b0; if_addr = '0; ld_addr = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic chk_fault(input string req, input logic f, input logic [2:0] c, input logic [31:0] a);
    chk({req, " fault"}, {31'b0, fault}, {31'b0, f});
    chk({req, " cause"}, {29'b0, fault_cause}, {29'b0, c});
    chk({req, " addr"},  fault_addr, a);
  endtask

  task automatic t_reset();
    do_reset();
    chk_fault("R11 reset", 1'b0, 3'd0, 32'h0);
    svc();
    chk("R11 svc after reset", {31'b0, s_svc}, 32'd0);
    chk_fault("R6 svc fault", 1'b1, 3'd4, 32'h0);
  endtask

  task automatic t_code();
    do_reset();
    fetch(32'h0000_0100);
    chk("R2 code fetch", {31'b0, s_if}, 32'd1);
    fetch(32'h0000_FFFC);
    chk("R2 code last word", {31'b0, s_if}, 32'd1);
    load(32'h1000_0000);
    chk("R3 sram load grant", {31'b0, s_ld}, 32'd1);
    chk("R8 sram load data same cycle", s_rd, MEMD);
    load(32'h0000_0040);
    chk("R3 code rom load data", s_rd, MEMD);
    chk_fault("R2 no fault", 1'b0, 3'd0, 32'h0);
  endtask

  task automatic t_outside();
    do_reset();
    fetch(32'h1000_0000);
    chk("R1 sram fetch", {31'b0, s_if}, 32'd0);
    chk_fault("R1 range fault", 1'b1, 3'd1, 32'h1000_0000);
    fetch(32'h0001_0000);
    chk("R1 just past code rom", {31'b0, s_if}, 32'd0);
    chk_fault("R7 first kept", 1'b1, 3'd1, 32'h1000_0000);
    do_reset();
    chk_fault("R7 reset clears", 1'b0, 3'd0, 32'h0);
  endtask

  task automatic t_exec_only();
    do_reset();
    fetch(32'h0000_0000);
    load(32'h0002_0010);
    chk("R3 boot load grant", {31'b0, s_ld}, 32'd0);
    chk("R3 boot load zero", s_rd, 32'h0);
    chk_fault("R3 xo fault", 1'b1, 3'd2, 32'h0002_0010);
    load(32'h0003_0000);
    chk("R3 sys load zero", s_rd, 32'h0);
    chk_fault("R7 cause held", 1'b1, 3'd2, 32'h0002_0010);
  endtask

  task automatic t_entry();
    do_reset();
    fetch(32'h0000_0100);
    fetch(32'h0002_0004);
    chk("R4 bad boot entry", {31'b0, s_if}, 32'd0);
    chk_fault("R4 entry fault", 1'b1, 3'd3, 32'h0002_0004);
    fetch(32'h0002_0008);
    chk("R9 still outside boot", {31'b0, s_if}, 32'd0);
    fetch(32'h0002_0100);
    chk("R4 good boot entry", {31'b0, s_if}, 32'd1);
    fetch(32'h0002_0104);
    chk("R5 boot sequential", {31'b0, s_if}, 32'd1);
    fetch(32'h0002_0ABC);
    chk("R5 boot jump inside", {31'b0, s_if}, 32'd1);
    fetch(32'h0003_0044);
    chk("R4 bad sys entry", {31'b0, s_if}, 32'd0);
    fetch(32'h0003_0040);
    chk("R4 good sys entry", {31'b0, s_if}, 32'd1);
    svc();
    chk("R6 svc from sys", {31'b0, s_svc}, 32'd1);
    fetch(32'h0000_0200);
    chk("R2 return to code", {31'b0, s_if}, 32'd1);
    svc();
    chk("R6 svc from code", {31'b0, s_svc}, 32'd0);
    chk_fault("R7 first entry fault kept", 1'b1, 3'd3, 32'h0002_0004);
  endtask

  task automatic t_sys_bounds();
    do_reset();
    fetch(32'h0003_0000);
    chk("R4 sys entry from reset", {31'b0, s_if}, 32'd1);
    svc();
    chk("R6 svc granted", {31'b0, s_svc}, 32'd1);
    fetch(32'h0003_3FFC);
    chk("R5 sys last word", {31'b0, s_if}, 32'd1);
    chk_fault("R6 clean", 1'b0, 3'd0, 32'h0);
    fetch(32'h0003_4000);
    chk("R1 past sys rom", {31'b0, s_if}, 32'd0);
    chk_fault("R1 edge fault", 1'b1, 3'd1, 32'h0003_4000);
  endtask

  task automatic t_priority();
    do_reset();
    cyc(1'b1, 32'h1000_0000, 1'b1, 32'h0002_0000, 1'b1);
    chk_fault("R10 fetch wins", 1'b1, 3'd1, 32'h1000_0000);
    do_reset();
    cyc(1'b0, 32'h0, 1'b1, 32'h0003_0008, 1'b1);
    chk_fault("R10 load beats svc", 1'b1, 3'd2, 32'h0003_0008);
    do_reset();
    cyc(1'b1, 32'h0002_0040, 1'b1, 32'h0002_0000, 1'b0);
    chk_fault("R10 entry beats load", 1'b1, 3'd3, 32'h0002_0040);
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    report();
  end

  initial begin
    mem_rdata = MEMD;
    rst_n = 1'b0;
    if_req = 1'b0; ld_req = 1'b0; svc_req = 1'b0; if_addr = '0; ld_addr = '0;
    @(negedge clk);
    t_reset();
    t_code();
    t_outside();
    t_exec_only();
    t_entry();
    t_sys_bounds();
    t_priority();
    report();
  end

endmodule